// File: doc/BRIEF.md
# Four-Way Exact LRU Rank Updater

This block keeps the replacement state for a four-way set-associative cache and holds exact least-recently-used order for every set. Each way of a set carries a 2-bit rank: 0 marks the way touched most recently and 3 marks the way touched longest ago. The ranks of one set always form a permutation of 0 to 3. The rank state for all sets lives in one array, and a set-number input selects the entry to read and update.

Each cycle the cache controller may present an access. The access carries the set number, a hit flag and, for a hit, the way that matched. The block works out the new ranks for that set and writes them back at the clock edge. A combinational decode of the same set's ranks gives the way with rank 3 as the victim for the next miss. A classifier sorts each access into one of three update kinds. UPD_HOLD is taken when there is no access, or on a hit to the rank-0 way, and writes nothing new. UPD_PROMOTE is taken on a hit to a way of rank 1 to 3. UPD_FILL is taken on a miss, where the victim way is the one filled. Every access cycle makes exactly one of these transitions for the addressed set. Tag comparison and data storage are not part of this block.

Top module: `lru_order_unit`

## Requirements
- R1: After reset every set holds rank 3 in way 0, rank 2 in way 1, rank 1 in way 2 and rank 0 in way 3, so `rank_view` reads 8'h1B and `victim_way` reads 0.
- R2: `rank_view` shows the ranks of set `acc_set`, with the rank of way i at bits [2i+1:2i]. `victim_way` is combinationally the number of the way whose rank in that set is 3.
- R3: On a miss (`acc_valid`=1, `acc_hit`=0) the victim way takes rank 0 and each other way's rank rises by 1. `acc_way` has no effect on a miss.
- R4: On a hit to the way whose rank is 0, no rank changes (UPD_HOLD).
- R5: On a hit to a way of rank k>0, that way takes rank 0, ways with a rank below k rise by 1, and ways with a rank above k keep it (UPD_PROMOTE).
- R6: With `acc_valid`=0, no rank of any set changes.
- R7: An access changes only the ranks of the set it addresses.
- R8: The four ranks of every set are always distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_W | Set addressed for read and update |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | 2 | Way that hit (ignored on a miss) |
| victim_way | output | 2 | Way of rank 3 in set `acc_set` |
| rank_view | output | 8 | Ranks of set `acc_set`, 2 bits per way |

## Verification
The hard part is reaching every one of the 24 rank orders of a set. Only certain sequences of hits to ranks 1, 2 and 3 lead to each order, and misses keep collapsing the order back into a rotation. The bench drives a long pseudo-random stream of hits to chosen ways and misses, spread over a small number of sets. It records each order seen in set 0 and requires all 24 to appear. Idle cycles that sweep the set input then compare every set against the bench's model, which shows that idle cycles and other sets leave the ranks untouched.

// File: rtl/lru_order_pkg.sv
package lru_order_pkg;
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_PROMOTE = 2'd1,
        UPD_FILL    = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int WAYS = 4,
    parameter int RW   = $clog2(WAYS)
) (
    input  logic [WAYS*RW-1:0] ranks,
    output logic [RW-1:0]      victim
);
    localparam logic [RW-1:0] OLDEST = RW'(WAYS - 1);

    logic [WAYS-1:0] is_oldest;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign is_oldest[w] = (ranks[w*RW +: RW] == OLDEST);
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (is_oldest[w]) victim = RW'(w);
        end
    end
endmodule

// File: rtl/lru_rank_next.sv
module lru_rank_next
    import lru_order_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int RW   = $clog2(WAYS)
) (
    input  logic [WAYS*RW-1:0] cur,
    input  logic               valid,
    input  logic               hit,
    input  logic [RW-1:0]      hit_way,
    input  logic [RW-1:0]      victim,
    output upd_kind_e          kind,
    output logic [WAYS*RW-1:0] nxt
);
    logic [RW-1:0] target;
    logic [RW-1:0] k_rank;

    assign target = hit ? hit_way : victim;
    assign k_rank = cur[target*RW +: RW];

    always_comb begin
        if (!valid)                      kind = UPD_HOLD;
        else if (!hit)                   kind = UPD_FILL;
        else if (k_rank == '0)           kind = UPD_HOLD;
        else                             kind = UPD_PROMOTE;
    end

    always_comb begin
        nxt = cur;
        unique case (kind)
            UPD_HOLD: nxt = cur;
            UPD_PROMOTE, UPD_FILL: begin
                for (int w = 0; w < WAYS; w++) begin
                    if (RW'(w) == target)
                        nxt[w*RW +: RW] = '0;
                    else if (cur[w*RW +: RW] < k_rank)
                        nxt[w*RW +: RW] = cur[w*RW +: RW] + RW'(1);
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/lru_rank_store.sv
module lru_rank_store #(
    parameter int WAYS  = 4,
    parameter int RW    = $clog2(WAYS),
    parameter int SETS  = 16,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SET_W-1:0]   sel,
    input  logic [WAYS*RW-1:0] wr_ranks,
    output logic [WAYS*RW-1:0] rd_ranks
);
    logic [WAYS*RW-1:0] init_ranks;
    logic [WAYS*RW-1:0] mem [SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_init
        assign init_ranks[w*RW +: RW] = RW'(WAYS - 1 - w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) mem[s] <= init_ranks;
        end else if (wr_en) begin
            mem[sel] <= wr_ranks;
        end
    end

    assign rd_ranks = mem[sel];
endmodule

// File: rtl/lru_order_unit.sv
module lru_order_unit
    import lru_order_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int RW    = $clog2(WAYS),
    parameter int SET_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [SET_W-1:0]   acc_set,
    input  logic               acc_hit,
    input  logic [RW-1:0]      acc_way,
    output logic [RW-1:0]      victim_way,
    output logic [WAYS*RW-1:0] rank_view
);
    logic [WAYS*RW-1:0] cur_ranks;
    logic [WAYS*RW-1:0] nxt_ranks;
    upd_kind_e          upd_kind;

    lru_rank_store #(.WAYS(WAYS), .RW(RW), .SETS(SETS), .SET_W(SET_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_kind != UPD_HOLD),
        .sel      (acc_set),
        .wr_ranks (nxt_ranks),
        .rd_ranks (cur_ranks)
    );

    lru_victim_pick #(.WAYS(WAYS), .RW(RW)) u_pick (
        .ranks  (cur_ranks),
        .victim (victim_way)
    );

    lru_rank_next #(.WAYS(WAYS), .RW(RW)) u_next (
        .cur     (cur_ranks),
        .valid   (acc_valid),
        .hit     (acc_hit),
        .hit_way (acc_way),
        .victim  (victim_way),
        .kind    (upd_kind),
        .nxt     (nxt_ranks)
    );

    assign rank_view = cur_ranks;
endmodule

// File: rtl/lru_order_chk.sv
module lru_order_chk #(
    parameter int WAYS = 4,
    parameter int RW   = $clog2(WAYS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_hit,
    input logic [RW-1:0]      acc_way,
    input logic [RW-1:0]      victim_way,
    input logic [WAYS*RW-1:0] rank_view,
    input logic [WAYS*RW-1:0] nxt_ranks
);
    logic [WAYS*RW-1:0] reset_ranks;
    logic               perm_ok;

    always_comb begin
        for (int w = 0; w < WAYS; w++) reset_ranks[w*RW +: RW] = RW'(WAYS - 1 - w);
    end

    always_comb begin
        perm_ok = 1'b1;
        for (int v = 0; v < WAYS; v++) begin
            int n;
            n = 0;
            for (int w = 0; w < WAYS; w++)
                if (rank_view[w*RW +: RW] == RW'(v)) n++;
            if (n != 1) perm_ok = 1'b0;
        end
    end

    // R8
    perm_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n) perm_ok);

    // R1
    reset_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rank_view == reset_ranks);

    // R2
    victim_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rank_view[victim_way*RW +: RW] == RW'(WAYS - 1));

    // R3
    fill_to_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |-> nxt_ranks[victim_way*RW +: RW] == '0);

    // R4
    hit_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && rank_view[acc_way*RW +: RW] == '0) |-> nxt_ranks == rank_view);

    // R5
    hit_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |-> nxt_ranks[acc_way*RW +: RW] == '0);
endmodule

bind lru_order_unit lru_order_chk #(.WAYS(WAYS), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .rank_view  (rank_view),
    .nxt_ranks  (nxt_ranks)
);

// File: tb/sim_lru_order_unit.sv
module sim_lru_order_unit;
    localparam int SETS = 4;
    localparam int SW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic          acc_hit = 1'b0;
    logic [1:0]    acc_way = '0;
    logic [1:0]    victim_way;
    logic [7:0]    rank_view;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    logic [7:0] model [SETS];
    logic       seen [256];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    lru_order_unit #(.SETS(SETS)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .victim_way(victim_way), .rank_view(rank_view)
    );

    function automatic logic [1:0] oldest(input logic [7:0] r);
        logic [1:0] v;
        v = 2'd0;
        for (int w = 0; w < 4; w++) if (r[w*2 +: 2] == 2'd3) v = 2'(w);
        return v;
    endfunction

    function automatic logic distinct(input logic [7:0] r);
        logic [3:0] m;
        m = '0;
        for (int w = 0; w < 4; w++) m[r[w*2 +: 2]] = 1'b1;
        return m == 4'hF;
    endfunction

    function automatic logic [7:0] apply(input logic [7:0] r, input logic hit, input logic [1:0] way);
        logic [1:0] t;
        logic [1:0] k;
        logic [7:0] o;
        t = hit ? way : oldest(r);
        k = r[t*2 +: 2];
        o = r;
        for (int w = 0; w < 4; w++) begin
            if (2'(w) == t)              o[w*2 +: 2] = 2'd0;
            else if (r[w*2 +: 2] < k)    o[w*2 +: 2] = r[w*2 +: 2] + 2'd1;
        end
        return o;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic observe(input string tag, input logic [SW-1:0] s);
        check8({tag, " R2 ranks"}, rank_view, model[s]);
        check8({tag, " R2 victim"}, {6'd0, victim_way}, {6'd0, oldest(model[s])});
        check8({tag, " R8 distinct"}, {7'd0, distinct(rank_view)}, 8'd1);
    endtask

    task automatic step(input string tag, input logic v, input logic [SW-1:0] s,
                        input logic h, input logic [1:0] w);
        @(negedge clk);
        acc_valid = v; acc_set = s; acc_hit = h; acc_way = w;
        #1;
        observe(tag, s);
        if (s == '0) seen[rank_view] = 1'b1;
        @(posedge clk);
        if (v) model[s] = apply(model[s], h, w);
    endtask

    task automatic sweep_idle(input string tag);
        for (int s = 0; s < SETS; s++) step(tag, 1'b0, SW'(s), 1'b1, 2'd1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        for (int s = 0; s < SETS; s++) model[s] = 8'h1B;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset order in every set
        for (int s = 0; s < SETS; s++) begin
            acc_set = SW'(s);
            #1;
            check8("R1 reset ranks", rank_view, 8'h1B);
            check8("R1 reset victim", {6'd0, victim_way}, 8'd0);
            @(negedge clk);
        end

        // R3: miss on set 1 with acc_way pointing elsewhere
        step("R3 miss", 1'b1, 2'd1, 1'b0, 2'd2);
        step("R3 after miss", 1'b0, 2'd1, 1'b0, 2'd0);
        check8("R3 miss result", rank_view, 8'h6C);
        check8("R3 new victim", {6'd0, victim_way}, 8'd1);

        // R4: hit on rank-0 way (way0 of set 1)
        step("R4 hit top", 1'b1, 2'd1, 1'b1, 2'd0);
        step("R4 after", 1'b0, 2'd1, 1'b0, 2'd0);
        check8("R4 hold", rank_view, 8'h6C);

        // R5: hit on way2 (rank 2) of set 1 -> w0=1,w1=3,w2=0,w3=2
        step("R5 hit mid", 1'b1, 2'd1, 1'b1, 2'd2);
        step("R5 after", 1'b0, 2'd1, 1'b0, 2'd0);
        check8("R5 promote", rank_view, 8'b10_00_11_01);

        // R6 / R7: idle sweep, other sets untouched
        sweep_idle("R6 R7 idle sweep");

        // Near-exhaustive pseudo-random stream
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R3 R4 R5 stream", lfsr[7:0] != 8'h00, lfsr[1:0], lfsr[4:2] != 3'd0, lfsr[6:5]);
            if (n % 500 == 499) sweep_idle("R6 R7 periodic sweep");
        end
        sweep_idle("R7 final sweep");

        begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < 256; i++) if (seen[i]) cnt++;
            check8("R5 R8 all 24 orders reached", 8'(cnt), 8'd24);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule